// File: doc/BRIEF.md
# Serial Flash Command Front End with Status and Write Protection

This block sits between a serial peripheral port and the program path of a small serial flash array. It decodes the opcodes that set and clear the write-enable latch, read and write the status byte, and request a single-byte program. It owns the status byte: the busy flag, the write-enable latch, two block-protect bits and a pin-enable bit. It also honours an external active-low write-protect input. A program or status write is committed only when chip select rises cleanly after the last expected byte. An accepted instruction starts an internal write timer that keeps the block busy for `WCYC` clocks.

The serial pins are oversampled in the system clock domain. SCK must therefore stay in each phase for at least six system clocks. The port uses SPI mode 0 and sends bytes MSB first. The array is represented only by a one-cycle request strobe with an address and a data byte. Storage, erase and read data are handled elsewhere.

Top module: `spi_flash_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `busy` is low, `so` is low and no `prog_req` is issued.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x04 clears it, at any level of `wp_n` and whether or not the pin-enable bit is set.
- R3: Opcode 0x05 returns the status byte on `so`, MSB first, changing after SCK falls. The byte is re-captured at the start of every following byte for as long as CS# stays low. The layout is: bit 7 pin-enable, bits 3:2 protect code, bit 1 write-enable latch, bit 0 busy.
- R4: When no write cycle runs, status bits 6..4 read as zero, even after a status write that carried ones in those bits.
- R5: While a write cycle runs, every status byte read is 0xFF and every other opcode has no effect.
- R6: Opcode 0x01 followed by exactly one byte loads the pin-enable bit from bit 7 and the protect code from bits 3:2. It needs the latch set and is committed at the rise of CS#.
- R7: The protect code locks part of the address space: 00 locks nothing, 01 locks the top quarter (two address MSBs = 11), 10 locks the top half (address MSB = 1), 11 locks everything. A program to a locked address raises no request and starts no cycle.
- R8: With the pin-enable bit set and `wp_n` low, a status write is rejected. With the pin-enable bit clear, `wp_n` has no effect.
- R9: Opcode 0x02 takes three address bytes (MSB first; only the low `ADDR_W` bits are used) and then one data byte. When it is accepted at the rise of CS#, `prog_req` pulses for one clock with `prog_addr` and `prog_data` valid.
- R10: An accepted status write or program holds `busy` high for exactly `WCYC` clocks and clears the write-enable latch when the cycle ends.
- R11: No cycle starts, and the latch keeps its value, in any of these cases: the latch is clear; CS# rises in mid-byte; a byte is missing; an extra byte follows; the opcode is unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| busy | output | 1 | Internal write cycle in progress |
| prog_req | output | 1 | One-clock program request to the array |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data byte |

## Verification
The end of the write timer, which clears the latch and drops the busy code, can land in the same clock as the per-byte status capture of an ongoing status read. The bench starts an accepted program and then holds one status read open across the expiry for eight bytes. Each captured byte must be either all ones or exactly the final idle value, never a blend of the two. The sequence must move from 0xFF to 0x00 exactly once, and no byte may go back to 0xFF after that.

// File: rtl/spiwp_pkg.sv
package spiwp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [2:0] {
    C_OP, C_ADDR, C_DATA, C_SREG, C_ARM_SREG, C_ARM_PROG, C_RDSR, C_SKIP
  } cmd_st_t;
endpackage

// File: rtl/spiwp_rx.sv
module spiwp_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  output logic       cs_act,
  output logic       cs_rise,
  output logic       sck_fall,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic [2:0] bit_idx
);
  logic [1:0] cs_q, sck_q, si_q;
  logic       sck_d, cs_d;
  logic [6:0] shreg, shreg_nx;
  logic [2:0] bit_nx;
  logic       vld_nx, rise;

  assign rise     = sck_q[1] & ~sck_d & ~cs_q[1];
  assign sck_fall = ~sck_q[1] & sck_d & ~cs_q[1];
  assign cs_act   = ~cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_d;

  always_comb begin
    shreg_nx = shreg;
    bit_nx   = bit_idx;
    vld_nx   = 1'b0;
    if (cs_q[1]) begin
      bit_nx = 3'd0;
    end else if (rise) begin
      shreg_nx = {shreg[5:0], si_q[1]};
      bit_nx   = bit_idx + 3'd1;
      vld_nx   = (bit_idx == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 2'b11;
      sck_q    <= 2'b00;
      si_q     <= 2'b00;
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      shreg    <= '0;
      bit_idx  <= '0;
      byte_vld <= 1'b0;
      byte_val <= '0;
    end else begin
      cs_q     <= {cs_q[0], cs_n};
      sck_q    <= {sck_q[0], sck};
      si_q     <= {si_q[0], si};
      sck_d    <= sck_q[1];
      cs_d     <= cs_q[1];
      shreg    <= shreg_nx;
      bit_idx  <= bit_nx;
      byte_vld <= vld_nx;
      if (vld_nx) byte_val <= {shreg[6:0], si_q[1]};
    end
  end

  // R3: a finished byte always leaves the bit counter at a byte boundary
  p_byte_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (bit_idx == 3'd0));
endmodule

// File: rtl/spiwp_stat.sv
module spiwp_stat #(
  parameter int WCYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       sreg_wr,
  input  logic       sreg_pen,
  input  logic [1:0] sreg_bp,
  input  logic       cyc_start,
  output logic       busy,
  output logic       wel,
  output logic       wpen,
  output logic [1:0] bp,
  output logic [7:0] stat_byte
);
  localparam int CW = $clog2(WCYC + 1);

  logic [CW-1:0] cnt, cnt_nx;
  logic          wel_nx, wpen_nx;
  logic [1:0]    bp_nx;

  assign busy      = (cnt != '0);
  assign stat_byte = busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};

  always_comb begin
    cnt_nx  = cnt;
    wel_nx  = wel;
    wpen_nx = wpen;
    bp_nx   = bp;
    if (cyc_start)    cnt_nx = CW'(WCYC);
    else if (busy)    cnt_nx = cnt - CW'(1);
    if (busy && cnt == CW'(1)) wel_nx = 1'b0;
    else if (wel_clr)          wel_nx = 1'b0;
    else if (wel_set)          wel_nx = 1'b1;
    if (sreg_wr) begin
      wpen_nx = sreg_pen;
      bp_nx   = sreg_bp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wel  <= 1'b0;
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else begin
      cnt  <= cnt_nx;
      wel  <= wel_nx;
      wpen <= wpen_nx;
      bp   <= bp_nx;
    end
  end

  p_start_needs_wel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> wel);
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> busy);
  p_end_clears_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  p_busy_wel_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(wel));
endmodule

// File: rtl/spiwp_lock.sv
module spiwp_lock #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  logic top_q, top_h;
  assign top_h = addr[ADDR_W-1];
  assign top_q = addr[ADDR_W-1] & addr[ADDR_W-2];

  always_comb begin
    unique case (bp)
      2'b00:   locked = 1'b0;
      2'b01:   locked = top_q;
      2'b10:   locked = top_h;
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_flash_wp_ctrl.sv
module spi_flash_wp_ctrl #(
  parameter int ADDR_W = 17,
  parameter int WCYC   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wp_n,
  output logic              so,
  output logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data
);
  import spiwp_pkg::*;

  logic [1:0] rst_q, wp_q;
  logic       rst_s, wp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  logic cs_act, cs_rise, sck_fall, byte_vld;
  logic [7:0] byte_val;
  logic [2:0] bit_idx;

  spiwp_rx u_rx (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .sck(sck), .si(si),
    .cs_act(cs_act), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .byte_vld(byte_vld), .byte_val(byte_val), .bit_idx(bit_idx)
  );

  cmd_st_t           st, st_nx;
  logic [1:0]        acnt, acnt_nx;
  logic [ADDR_W-1:0] addr_r, addr_nx;
  logic [7:0]        data_r, data_nx;
  logic [2:0]        sreg_r, sreg_nx;
  logic [7:0]        sh, sh_nx;
  logic              so_nx;
  logic              wel_set, wel_clr, sreg_go, prog_go, armed;
  logic              wel, wpen, locked;
  logic [1:0]        bp;
  logic [7:0]        stat_byte;

  spiwp_stat #(.WCYC(WCYC)) u_stat (
    .clk(clk), .rst_n(rst_s), .wel_set(wel_set), .wel_clr(wel_clr),
    .sreg_wr(sreg_go), .sreg_pen(sreg_r[2]), .sreg_bp(sreg_r[1:0]),
    .cyc_start(sreg_go | prog_go), .busy(busy), .wel(wel), .wpen(wpen),
    .bp(bp), .stat_byte(stat_byte)
  );

  spiwp_lock #(.ADDR_W(ADDR_W)) u_lock (
    .bp(bp), .addr(addr_r), .locked(locked)
  );

  assign armed   = cs_rise && (bit_idx == 3'd0);
  assign sreg_go = armed && (st == C_ARM_SREG) && wel && !(wpen && !wp_s);
  assign prog_go = armed && (st == C_ARM_PROG) && wel && !locked;
  assign prog_addr = addr_r;
  assign prog_data = data_r;
  assign wp_s      = wp_q[1];

  always_comb begin
    st_nx   = st;
    acnt_nx = acnt;
    addr_nx = addr_r;
    data_nx = data_r;
    sreg_nx = sreg_r;
    wel_set = 1'b0;
    wel_clr = 1'b0;
    if (!cs_act) begin
      st_nx   = C_OP;
      acnt_nx = 2'd0;
    end else if (byte_vld) begin
      unique case (st)
        C_OP: begin
          if (busy) begin
            st_nx = (byte_val == OP_RDSR) ? C_RDSR : C_SKIP;
          end else begin
            st_nx = C_SKIP;
            unique case (byte_val)
              OP_WREN: wel_set = 1'b1;
              OP_WRDI: wel_clr = 1'b1;
              OP_RDSR: st_nx = C_RDSR;
              OP_WRSR: st_nx = C_SREG;
              OP_PROG: st_nx = C_ADDR;
              default: st_nx = C_SKIP;
            endcase
          end
        end
        C_ADDR: begin
          addr_nx = ADDR_W'({addr_r, byte_val});
          acnt_nx = acnt + 2'd1;
          if (acnt == 2'd2) st_nx = C_DATA;
        end
        C_DATA: begin
          data_nx = byte_val;
          st_nx   = C_ARM_PROG;
        end
        C_SREG: begin
          sreg_nx = {byte_val[7], byte_val[3:2]};
          st_nx   = C_ARM_SREG;
        end
        C_ARM_SREG, C_ARM_PROG: st_nx = C_SKIP;
        default: st_nx = st;
      endcase
    end
  end

  always_comb begin
    so_nx = so;
    sh_nx = sh;
    if (!cs_act) begin
      so_nx = 1'b0;
    end else if (st == C_RDSR && sck_fall) begin
      if (bit_idx == 3'd0) begin
        so_nx = stat_byte[7];
        sh_nx = {stat_byte[6:0], 1'b0};
      end else begin
        so_nx = sh[7];
        sh_nx = {sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wp_q     <= 2'b11;
      st       <= C_OP;
      acnt     <= 2'd0;
      addr_r   <= '0;
      data_r   <= '0;
      sreg_r   <= '0;
      sh       <= '0;
      so       <= 1'b0;
      prog_req <= 1'b0;
    end else begin
      wp_q     <= {wp_q[0], wp_n};
      st       <= st_nx;
      acnt     <= acnt_nx;
      addr_r   <= addr_nx;
      data_r   <= data_nx;
      sreg_r   <= sreg_nx;
      sh       <= sh_nx;
      so       <= so_nx;
      prog_req <= prog_go;
    end
  end

  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_s)
    prog_req |-> busy);
  p_req_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_s)
    prog_req |-> !locked);
  p_so_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !cs_act |=> !so);
  p_pin_guard_r8: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(wpen) && !$stable({wpen, bp})) |-> $past(wp_s));
endmodule

// File: tb/sim_spi_flash_wp_ctrl.sv
module sim_spi_flash_wp_ctrl;
  localparam int AW = 17;
  localparam int WC = 600;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, busy, prog_req;
  logic [AW-1:0] prog_addr;
  logic [7:0] prog_data;

  always #4 clk = ~clk;

  spi_flash_wp_ctrl #(.ADDR_W(AW), .WCYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data)
  );

  int n_chk = 0, n_bad = 0, busy_cnt = 0, req_cnt = 0;
  logic [AW-1:0] req_addr;
  logic [7:0] req_data;

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (prog_req) begin
      req_cnt++;
      req_addr = prog_addr;
      req_data = prog_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ck(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      ck(HP);
      rx[i] = so;
      sck = 1'b1;
      ck(HP);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx);
    logic [7:0] d;
    bits(tx, 8, d);
  endtask

  task automatic sel;
    cs_n = 1'b0;
    ck(HP);
  endtask

  task automatic desel;
    ck(HP);
    cs_n = 1'b1;
    ck(10);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel; xfer(op); desel;
  endtask

  task automatic rdsr(output logic [7:0] v);
    sel; xfer(8'h05); bits(8'h00, 8, v); desel;
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel; xfer(8'h01); xfer(v); desel;
  endtask

  task automatic prog(input logic [23:0] a, input logic [7:0] d);
    sel; xfer(8'h02); xfer(a[23:16]); xfer(a[15:8]); xfer(a[7:0]); xfer(d); desel;
  endtask

  task automatic idle;
    ck(WC + 20);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    ck(5);
    rst_n = 1'b1;
    ck(5);

    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 so", so, 0);
    rdsr(s);
    check("R1 status", s, 8'h00);
    check("R1 no request", req_cnt, 0);

    // R2 latch set and clear
    cmd1(8'h06); rdsr(s);
    check("R2 wren", s, 8'h02);
    cmd1(8'h04); rdsr(s);
    check("R2 wrdi", s, 8'h00);

    // R6 / R4 status write, unused bits read zero
    cmd1(8'h06);
    busy_cnt = 0;
    wrsr(8'h7C);
    idle;
    check("R10 wrsr busy length", busy_cnt, WC);
    rdsr(s);
    check("R4 R6 status after write", s, 8'h0C);
    cmd1(8'h06); wrsr(8'h00); idle;
    rdsr(s);
    check("R6 cleared protect", s, 8'h00);

    // R11 status write without latch
    wrsr(8'h0C); idle; rdsr(s);
    check("R11 wrsr without wel", s, 8'h00);

    // R8 pin-enable x pin level sweep
    for (int pe = 0; pe < 2; pe++) begin
      for (int wp = 0; wp < 2; wp++) begin
        wp_n = 1'b1;
        cmd1(8'h06); wrsr({pe[0], 7'b0}); idle;
        wp_n = wp[0];
        cmd1(8'h06);
        busy_cnt = 0;
        wrsr({pe[0], 3'b000, 2'b01, 2'b00}); idle;
        rdsr(s);
        if (pe == 1 && wp == 0) begin
          check("R8 rejected status", s, 8'h82);
          check("R8 no cycle", busy_cnt, 0);
          // R2 clear works with pin low and pin enabled
          cmd1(8'h04); rdsr(s);
          check("R2 wrdi under wp", s, 8'h80);
        end else begin
          check("R8 accepted status", s, {pe[0], 7'b0000100});
        end
      end
    end
    wp_n = 1'b1;
    cmd1(8'h06); wrsr(8'h00); idle;

    // R7 / R9 / R10 protect level x address sweep
    for (int b = 0; b < 4; b++) begin
      cmd1(8'h06); wrsr({4'b0, b[1:0], 2'b00}); idle;
      for (int q = 0; q < 4; q++) begin
        for (int e = 0; e < 2; e++) begin
          logic [AW-1:0] a;
          logic lk;
          a = {q[1:0], (e == 1) ? 15'h7FFF : 15'h0000};
          lk = (b == 3) || (b == 2 && q >= 2) || (b == 1 && q == 3);
          cmd1(8'h06);
          busy_cnt = 0; req_cnt = 0;
          prog({7'h50, a}, 8'(8'h3C ^ (b * 16 + q * 4 + e)));
          idle;
          check("R7 request count", req_cnt, lk ? 0 : 1);
          check("R10 busy length", busy_cnt, lk ? 0 : WC);
          if (!lk) begin
            check("R9 address", req_addr, a);
            check("R9 data", req_data, 8'(8'h3C ^ (b * 16 + q * 4 + e)));
          end
          rdsr(s);
          check("R11 R10 latch after", s, {4'b0, b[1:0], lk, 1'b0});
        end
      end
    end
    cmd1(8'h06); wrsr(8'h00); idle;

    // R11 incomplete or malformed programs
    cmd1(8'h06); req_cnt = 0;
    sel; xfer(8'h02); xfer(8'h00); xfer(8'h01); xfer(8'h02);
    bits(8'hA5, 4, s); desel;
    check("R11 mid-byte cs", req_cnt, 0);
    sel; xfer(8'h02); xfer(8'h00); xfer(8'h01); xfer(8'h02); desel;
    check("R11 missing data", req_cnt, 0);
    sel; xfer(8'h02); xfer(8'h00); xfer(8'h01); xfer(8'h02); xfer(8'h11); xfer(8'h22); desel;
    check("R11 extra byte", req_cnt, 0);
    cmd1(8'hAB); rdsr(s);
    check("R11 unknown opcode keeps latch", s, 8'h02);
    check("R11 no busy", busy, 0);
    cmd1(8'h04); prog(24'h000010, 8'h77); idle;
    check("R11 no wel no request", req_cnt, 0);

    // R5 opcodes ignored during a cycle; R3 continuous read across expiry
    cmd1(8'h06); req_cnt = 0;
    prog(24'h000020, 8'h99);
    prog(24'h000030, 8'h88);
    check("R5 program ignored while busy", req_cnt, 1);
    idle;
    cmd1(8'h06); req_cnt = 0;
    prog(24'h000040, 8'h66);
    begin
      logic seen_zero;
      logic [7:0] v;
      seen_zero = 1'b0;
      sel; xfer(8'h05);
      for (int k = 0; k < 8; k++) begin
        bits(8'h00, 8, v);
        if (k == 0) check("R5 first byte busy", v, 8'hFF);
        if (v != 8'hFF || seen_zero) check("R3 byte clean after expiry", v, 8'h00);
        if (v == 8'h00) seen_zero = 1'b1;
        if (k == 7) check("R3 final idle byte", v, 8'h00);
      end
      desel;
    end
    check("R9 single request", req_cnt, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule